// File: doc/BRIEF.md
# Interrupt Domain Register Decoder

This block is the 32-bit register front end of an interrupt domain that serves `NSRC` sources, where source 0 is reserved and never has state. A bus master issues single word requests. The decoder sorts each request into one of several register groups:

- the domain control word;
- two per-source arrays, one for the trigger mode and one for the delivery target;
- four bitmaps that set or clear pending and enable bits;
- five number registers, each of which acts on one source;
- a byte-swapped number alias;
- a message-generation word.

Every request gets one response on the next clock, carrying read data and an error flag.

The decoder keeps the per-source mode, pending and enable state itself. A write to a bitmap becomes one set or clear operation per selected source, all in the same cycle. Reads of the bitmaps are assembled from the per-source state. Level-sensitive sources accept a pending-set request only while their rectified input is active. The raw input levels come from a separate gateway. The pending, enable and domain-enable outputs feed a separate message forwarder. A write to the message-generation word also produces a one-cycle request to that forwarder.

Top module: `irq_regdec`

## Requirements
- R1: A request (`req_valid`=1) gets `rsp_valid`=1 exactly one cycle later. The request is rejected with `rsp_err`=1, `rsp_rdata`=0 and no state change when any of these holds: `req_size` is not 4, `req_addr[1:0]` is not 0, or the offset is not mapped. Bitmap words at or beyond ceil(NSRC/32) are not mapped, and neither are array words beyond source NSRC-1.
- R2: The domain control word at offset 0x0000 reads as 0x8000_0004 with bit 8 ORed in. Bit 8 is the domain interrupt enable, is driven on `ie_o`, and is the only writable bit.
- R3: The mode array word at offset 0x0004+4*(s-1) belongs to source s, for s from 1 to NSRC-1. A write with bit 10 set stores mode 0; otherwise the write stores bits 2:0. A read returns the stored mode. Mode codes: 0 inactive, 1 detached, 4 rising edge, 5 falling edge, 6 level high, 7 level low.
- R4: The target array word at offset 0x3004+4*(s-1) belongs to source s. It stores the write data with bit 11 forced to 0 and reads the stored value back.
- R5: A write to the set-pending bitmap word w (offset 0x1C00+4*w) requests a set of pending for source 32*w+i for each bit i that is 1. A read returns the pending bits, which are also driven on `pend_o`. Source 0 never becomes pending.
- R6: Pending-write acceptance depends on the mode:
  - A source in mode 0 ignores both set and clear requests.
  - A source in mode 6 or 7 accepts a set request only when its rectified input, sampled in the request cycle, is 1.
  - Modes 1, 4 and 5 accept set requests unconditionally.
  - Clear requests are accepted in every mode except 0.
- R7: A write to the clear-pending bitmap word w (offset 0x1D00+4*w) requests a clear of pending for the selected sources. A read returns the rectified inputs:
  - 0 in mode 0;
  - the inverted raw input in modes 5 and 7;
  - the raw input otherwise.
- R8: A write to the set-enable bitmap (offset 0x1E00+4*w) sets the enable bit of each selected source, and a write to the clear-enable bitmap (offset 0x1F00+4*w) clears it. The set-enable bitmap reads back the enable bits, which are also driven on `en_o`. The clear-enable bitmap reads as 0.
- R9: The number registers each act on the single source whose number is the write data:
  - 0x1CDC and 0x2000 set pending;
  - 0x1DDC clears pending;
  - 0x1EDC sets enable;
  - 0x1FDC clears enable.

  All five read as 0. Number 0, and any number of NSRC or above, has no effect.
- R10: A write to offset 0x2004 reverses the byte order of the write data and then sets pending for that source number, under the rules of R6. The register reads as 0.
- R11: A write to offset 0x3000 stores the data with bits 17:12 cleared, and a read returns the stored value. The cycle after the write, `msi_valid` is 1 for one cycle, with `msi_hart` equal to data bits 31:18 and `msi_eiid` equal to data bits 10:0.
- R12: After reset, `ie_o` is 0, `pend_o` and `en_o` are all 0, every mode is 0 and the message-generation word reads as 0. Target words hold no reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte offset in the register space |
| req_size | input | 3 | Access size in bytes; only 4 is accepted |
| req_wdata | input | 32 | Write data |
| src_in | input | NSRC-1 | Raw input levels of sources 1..NSRC-1 |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Request rejected |
| rsp_rdata | output | 32 | Read data, 0 for writes and errors |
| ie_o | output | 1 | Domain interrupt enable |
| pend_o | output | NSRC | Pending bit per source |
| en_o | output | NSRC | Enable bit per source |
| msi_valid | output | 1 | One-cycle message-generation request |
| msi_hart | output | 14 | Hart index of the generated message |
| msi_eiid | output | 11 | Identity of the generated message |

## Verification
Two things can land on the same clock edge: a pending-set request and a change in a level-sensitive source's input. The acceptance rule of R6 uses the input value sampled in the request cycle. The bench provokes this by changing `src_in` for a level-high source in the same cycle that it issues a set-by-number for that source, in both directions. A reference model evaluates the rule with the new input and is compared with `pend_o` on every clock. A single bitmap write also reaches several sources with different modes in one cycle; the bench checks that each source applies only its own acceptance rule.

// File: rtl/irqrd_pkg.sv
`timescale 1ns/1ps
package irqrd_pkg;

  typedef enum logic [3:0] {
    RG_NONE, RG_DOM, RG_CFG, RG_SETP, RG_SETPN, RG_CLRP, RG_CLRPN,
    RG_SETE, RG_SETEN, RG_CLRE, RG_CLREN, RG_LE, RG_BE, RG_GEN, RG_TGT
  } region_e;

  localparam int unsigned OFF_DOM   = 32'h0000;
  localparam int unsigned OFF_CFG   = 32'h0004;
  localparam int unsigned OFF_SETP  = 32'h1C00;
  localparam int unsigned OFF_SETPN = 32'h1CDC;
  localparam int unsigned OFF_CLRP  = 32'h1D00;
  localparam int unsigned OFF_CLRPN = 32'h1DDC;
  localparam int unsigned OFF_SETE  = 32'h1E00;
  localparam int unsigned OFF_SETEN = 32'h1EDC;
  localparam int unsigned OFF_CLRE  = 32'h1F00;
  localparam int unsigned OFF_CLREN = 32'h1FDC;
  localparam int unsigned OFF_LE    = 32'h2000;
  localparam int unsigned OFF_BE    = 32'h2004;
  localparam int unsigned OFF_GEN   = 32'h3000;
  localparam int unsigned OFF_TGT   = 32'h3004;

  localparam logic [31:0] DOM_FIXED = 32'h8000_0004;
  localparam logic [31:0] TGT_MASK  = 32'hFFFF_F7FF;
  localparam logic [31:0] GEN_MASK  = 32'hFFFC_0FFF;

  localparam logic [2:0] MD_OFF  = 3'd0;
  localparam logic [2:0] MD_FALL = 3'd5;
  localparam logic [2:0] MD_HI   = 3'd6;
  localparam logic [2:0] MD_LO   = 3'd7;

  function automatic logic [31:0] swap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

endpackage

// File: rtl/irqrd_decode.sv
`timescale 1ns/1ps
module irqrd_decode #(
  parameter int NSRC = 40,
  parameter int NW   = 2,
  parameter int AW   = 16
) (
  input  logic [AW-1:0]        addr,
  input  logic [2:0]           size,
  output irqrd_pkg::region_e   rg,
  output logic [AW-1:0]        idx
);
  import irqrd_pkg::*;

  localparam int unsigned ARR_BYTES = 4 * (NSRC - 1);
  localparam int unsigned BM_BYTES  = 4 * NW;

  int unsigned a;
  int unsigned tmp;

  always_comb begin
    a   = 32'(addr);
    rg  = RG_NONE;
    tmp = 0;
    if (addr[1:0] == 2'b00 && size == 3'd4) begin
      if (a == OFF_DOM) rg = RG_DOM;
      else if (a >= OFF_CFG && a < OFF_CFG + ARR_BYTES) begin
        rg = RG_CFG; tmp = ((a - OFF_CFG) >> 2) + 1;
      end
      else if (a >= OFF_SETP && a < OFF_SETP + BM_BYTES) begin
        rg = RG_SETP; tmp = (a - OFF_SETP) >> 2;
      end
      else if (a == OFF_SETPN) rg = RG_SETPN;
      else if (a >= OFF_CLRP && a < OFF_CLRP + BM_BYTES) begin
        rg = RG_CLRP; tmp = (a - OFF_CLRP) >> 2;
      end
      else if (a == OFF_CLRPN) rg = RG_CLRPN;
      else if (a >= OFF_SETE && a < OFF_SETE + BM_BYTES) begin
        rg = RG_SETE; tmp = (a - OFF_SETE) >> 2;
      end
      else if (a == OFF_SETEN) rg = RG_SETEN;
      else if (a >= OFF_CLRE && a < OFF_CLRE + BM_BYTES) begin
        rg = RG_CLRE; tmp = (a - OFF_CLRE) >> 2;
      end
      else if (a == OFF_CLREN) rg = RG_CLREN;
      else if (a == OFF_LE) rg = RG_LE;
      else if (a == OFF_BE) rg = RG_BE;
      else if (a == OFF_GEN) rg = RG_GEN;
      else if (a >= OFF_TGT && a < OFF_TGT + ARR_BYTES) begin
        rg = RG_TGT; tmp = ((a - OFF_TGT) >> 2) + 1;
      end
    end
    idx = AW'(tmp);
  end
endmodule

// File: rtl/irqrd_srcbank.sv
`timescale 1ns/1ps
module irqrd_srcbank #(
  parameter int NSRC = 40,
  parameter int AW   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  irqrd_pkg::region_e rg,
  input  logic [AW-1:0]      idx,
  input  logic [31:0]        wdata,
  input  logic [NSRC-1:1]    src_in,
  output logic [NSRC-1:0]    pend,
  output logic [NSRC-1:0]    en,
  output logic [NSRC-1:0]    rect,
  output logic [3*NSRC-1:0]  md_flat
);
  import irqrd_pkg::*;

  logic [31:0] num;
  assign num = (rg == RG_BE) ? swap32(wdata) : wdata;

  assign pend[0]      = 1'b0;
  assign en[0]        = 1'b0;
  assign rect[0]      = 1'b0;
  assign md_flat[2:0] = MD_OFF;

  for (genvar s = 1; s < NSRC; s++) begin : g_src
    localparam int WI = s / 32;
    localparam int BI = s % 32;
    logic [2:0] md_q;
    logic       pend_q, en_q;
    logic       bm, nh, set_p, clr_p, set_e, clr_e, cfg_we, lvl, rin;

    assign bm     = (idx == AW'(WI)) && wdata[BI];
    assign nh     = (num == 32'(s));
    assign set_p  = we && ((rg == RG_SETP && bm) ||
                    ((rg == RG_SETPN || rg == RG_LE || rg == RG_BE) && nh));
    assign clr_p  = we && ((rg == RG_CLRP && bm) || (rg == RG_CLRPN && nh));
    assign set_e  = we && ((rg == RG_SETE && bm) || (rg == RG_SETEN && nh));
    assign clr_e  = we && ((rg == RG_CLRE && bm) || (rg == RG_CLREN && nh));
    assign cfg_we = we && (rg == RG_CFG) && (idx == AW'(s));
    assign lvl    = (md_q == MD_HI) || (md_q == MD_LO);
    assign rin    = (md_q != MD_OFF) &&
                    (src_in[s] ^ ((md_q == MD_FALL) || (md_q == MD_LO)));

    always_ff @(posedge clk) begin
      if (rst) begin
        md_q   <= MD_OFF;
        pend_q <= 1'b0;
        en_q   <= 1'b0;
      end else begin
        if (cfg_we) md_q <= wdata[10] ? MD_OFF : wdata[2:0];
        if (md_q != MD_OFF) begin
          if (set_p && (!lvl || rin)) pend_q <= 1'b1;
          else if (clr_p)             pend_q <= 1'b0;
        end
        if (set_e)      en_q <= 1'b1;
        else if (clr_e) en_q <= 1'b0;
      end
    end

    assign pend[s]          = pend_q;
    assign en[s]            = en_q;
    assign rect[s]          = rin;
    assign md_flat[3*s +: 3] = md_q;
  end
endmodule

// File: rtl/irqrd_tgt_ram.sv
`timescale 1ns/1ps
module irqrd_tgt_ram #(
  parameter int NSRC = 40,
  localparam int SW  = $clog2(NSRC)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [SW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [SW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [NSRC];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/irq_regdec.sv
`timescale 1ns/1ps
module irq_regdec #(
  parameter int NSRC = 40,
  parameter int AW   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [2:0]       req_size,
  input  logic [31:0]      req_wdata,
  input  logic [NSRC-1:1]  src_in,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [31:0]      rsp_rdata,
  output logic             ie_o,
  output logic [NSRC-1:0]  pend_o,
  output logic [NSRC-1:0]  en_o,
  output logic             msi_valid,
  output logic [13:0]      msi_hart,
  output logic [10:0]      msi_eiid
);
  import irqrd_pkg::*;

  localparam int NW = (NSRC + 31) / 32;
  localparam int SW = $clog2(NSRC);

  region_e           rg;
  logic [AW-1:0]     idx;
  logic              bad, wr, rd;
  logic [NSRC-1:0]   rect;
  logic [3*NSRC-1:0] md_flat;
  logic [32*NW-1:0]  pend_pad, en_pad, rect_pad;
  logic [31:0]       rd_n, rd_q, tgt_q, gen_q;
  logic              ie_q, tsel_q;
  int                ii;

  irqrd_decode #(.NSRC(NSRC), .NW(NW), .AW(AW)) dec_i (
    .addr(req_addr), .size(req_size), .rg(rg), .idx(idx)
  );

  assign bad = (rg == RG_NONE);
  assign wr  = req_valid && req_write && !bad;
  assign rd  = req_valid && !req_write && !bad;

  irqrd_srcbank #(.NSRC(NSRC), .AW(AW)) bank_i (
    .clk(clk), .rst(rst), .we(wr), .rg(rg), .idx(idx), .wdata(req_wdata),
    .src_in(src_in), .pend(pend_o), .en(en_o), .rect(rect), .md_flat(md_flat)
  );

  irqrd_tgt_ram #(.NSRC(NSRC)) tgt_i (
    .clk(clk), .we(wr && rg == RG_TGT), .waddr(SW'(idx)),
    .wdata(req_wdata & TGT_MASK), .raddr(SW'(idx)), .rdata(tgt_q)
  );

  assign pend_pad = (32*NW)'(pend_o);
  assign en_pad   = (32*NW)'(en_o);
  assign rect_pad = (32*NW)'(rect);

  always_comb begin
    ii   = int'(idx);
    rd_n = '0;
    unique case (rg)
      RG_DOM:  rd_n = DOM_FIXED | {23'd0, ie_q, 8'd0};
      RG_CFG:  rd_n = {29'd0, md_flat[3*ii +: 3]};
      RG_SETP: rd_n = pend_pad[32*ii +: 32];
      RG_CLRP: rd_n = rect_pad[32*ii +: 32];
      RG_SETE: rd_n = en_pad[32*ii +: 32];
      RG_GEN:  rd_n = gen_q;
      default: rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q      <= 1'b0;
      gen_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rd_q      <= '0;
      tsel_q    <= 1'b0;
      msi_valid <= 1'b0;
      msi_hart  <= '0;
      msi_eiid  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && bad;
      rd_q      <= rd ? rd_n : '0;
      tsel_q    <= rd && (rg == RG_TGT);
      msi_valid <= wr && (rg == RG_GEN);
      if (wr && rg == RG_DOM) ie_q <= req_wdata[8];
      if (wr && rg == RG_GEN) begin
        gen_q    <= req_wdata & GEN_MASK;
        msi_hart <= req_wdata[31:18];
        msi_eiid <= req_wdata[10:0];
      end
    end
  end

  assign rsp_rdata = tsel_q ? tgt_q : rd_q;
  assign ie_o      = ie_q;
endmodule

// File: rtl/irqrd_chk.sv
`timescale 1ns/1ps
module irqrd_chk #(
  parameter int NSRC = 40,
  parameter int AW   = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_write,
  input logic [AW-1:0]   req_addr,
  input logic [2:0]      req_size,
  input logic            rsp_valid,
  input logic            ie_o,
  input logic [NSRC-1:0] pend_o,
  input logic [NSRC-1:0] en_o,
  input logic            msi_valid
);
  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R1
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R1
  bad_write_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && (req_size != 3'd4 || req_addr[1:0] != 2'b00))
    |=> ($stable(pend_o) && $stable(en_o) && $stable(ie_o)));
  // R2
  ie_only_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write && req_addr == '0) |=> $stable(ie_o));
  // R5
  pend_only_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write) |=> $stable(pend_o));
  // R8
  en_only_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write) |=> $stable(en_o));
  // R11
  msi_cause_chk: assert property (@(posedge clk) disable iff (rst)
    msi_valid |-> $past(req_valid && req_write && req_size == 3'd4 &&
                        req_addr == AW'(32'h3000)));
endmodule

bind irq_regdec irqrd_chk #(.NSRC(NSRC), .AW(AW)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
  .ie_o(ie_o), .pend_o(pend_o), .en_o(en_o), .msi_valid(msi_valid)
);

// File: tb/irq_regdec_tb.sv
`timescale 1ns/1ps
module irq_regdec_tb_top;
  localparam int N = 40;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_addr = 0;
  logic [2:0] req_size = 4;
  logic [31:0] req_wdata = 0;
  logic [N-1:1] src = '0;
  logic rsp_valid, rsp_err, ie_o, msi_valid;
  logic [31:0] rsp_rdata;
  logic [N-1:0] pend_o, en_o;
  logic [13:0] msi_hart;
  logic [10:0] msi_eiid;

  int checks = 0, errors = 0;
  bit cmp_on = 0, done = 0;

  int m_md[N];
  bit m_p[N], m_e[N], m_ie, m_msi;
  bit [31:0] m_gen, m_t[N], exp_rd;
  bit exp_err;

  irq_regdec #(.NSRC(N), .AW(16)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .src_in(src), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .ie_o(ie_o), .pend_o(pend_o), .en_o(en_o),
    .msi_valid(msi_valid), .msi_hart(msi_hart), .msi_eiid(msi_eiid)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit m_rect(int n);
    if (m_md[n] == 0) return 0;
    return src[n] ^ (m_md[n] == 5 || m_md[n] == 7);
  endfunction

  function automatic void m_wp(bit [31:0] n, bit v);
    if (n < 1 || n >= N) return;
    if (m_md[n] == 0) return;
    if (v && (m_md[n] == 6 || m_md[n] == 7) && !m_rect(n)) return;
    m_p[n] = v;
  endfunction

  function automatic void m_we(bit [31:0] n, bit v);
    if (n < 1 || n >= N) return;
    m_e[n] = v;
  endfunction

  function automatic bit [N-1:0] vec_p();
    bit [N-1:0] r = '0;
    for (int i = 1; i < N; i++) r[i] = m_p[i];
    return r;
  endfunction

  function automatic bit [N-1:0] vec_e();
    bit [N-1:0] r = '0;
    for (int i = 1; i < N; i++) r[i] = m_e[i];
    return r;
  endfunction

  // behavioural reference of one access; evaluated with pre-access state
  function automatic void model(bit w, int a, int sz, bit [31:0] d);
    int s, wd;
    exp_err = 0; exp_rd = 0; m_msi = 0;
    if (a % 4 != 0 || sz != 4) exp_err = 1;
    else if (a == 0) begin
      exp_rd = 32'h8000_0004 | (32'(m_ie) << 8);
      if (w) m_ie = d[8];
    end else if (a >= 4 && a < 4 + 4*(N-1)) begin
      s = (a - 4) / 4 + 1; exp_rd = 32'(m_md[s]);
      if (w) m_md[s] = d[10] ? 0 : int'(d[2:0]);
    end else if (a >= 'h1C00 && a < 'h1C08) begin
      wd = (a - 'h1C00) / 4;
      for (int i = 0; i < 32; i++) if (32*wd+i < N) exp_rd[i] = m_p[32*wd+i];
      if (w) for (int i = 0; i < 32; i++) if (d[i]) m_wp(32*wd+i, 1);
    end else if (a >= 'h1D00 && a < 'h1D08) begin
      wd = (a - 'h1D00) / 4;
      for (int i = 0; i < 32; i++)
        if (32*wd+i < N && 32*wd+i > 0) exp_rd[i] = m_rect(32*wd+i);
      if (w) for (int i = 0; i < 32; i++) if (d[i]) m_wp(32*wd+i, 0);
    end else if (a >= 'h1E00 && a < 'h1E08) begin
      wd = (a - 'h1E00) / 4;
      for (int i = 0; i < 32; i++) if (32*wd+i < N) exp_rd[i] = m_e[32*wd+i];
      if (w) for (int i = 0; i < 32; i++) if (d[i]) m_we(32*wd+i, 1);
    end else if (a >= 'h1F00 && a < 'h1F08) begin
      wd = (a - 'h1F00) / 4;
      if (w) for (int i = 0; i < 32; i++) if (d[i]) m_we(32*wd+i, 0);
    end else if (a == 'h1CDC || a == 'h2000) begin if (w) m_wp(d, 1); end
    else if (a == 'h1DDC) begin if (w) m_wp(d, 0); end
    else if (a == 'h1EDC) begin if (w) m_we(d, 1); end
    else if (a == 'h1FDC) begin if (w) m_we(d, 0); end
    else if (a == 'h2004) begin
      if (w) m_wp({d[7:0], d[15:8], d[23:16], d[31:24]}, 1);
    end else if (a == 'h3000) begin
      exp_rd = m_gen;
      if (w) begin m_gen = d & ~(32'h3F << 12); m_msi = 1; end
    end else if (a >= 'h3004 && a < 'h3004 + 4*(N-1)) begin
      s = (a - 'h3004) / 4 + 1; exp_rd = m_t[s];
      if (w) m_t[s] = d & ~(32'h1 << 11);
    end else exp_err = 1;
    if (exp_err || w) exp_rd = 0;
  endfunction

  // called at a negedge; returns at the negedge after the response
  task automatic acc(input string req, input bit w, input int a,
                     input bit [31:0] d, input int sz = 4);
    req_valid = 1; req_write = w; req_addr = 16'(a);
    req_size = 3'(sz); req_wdata = d;
    @(posedge clk);
    model(w, a, sz, d);
    @(negedge clk);
    req_valid = 0;
    chk({req, " rsp_valid (R1)"}, 64'(rsp_valid), 64'd1);
    chk({req, " rsp_err (R1)"}, 64'(rsp_err), 64'(exp_err));
    chk({req, " rdata"}, 64'(rsp_rdata), 64'(exp_rd));
    chk({req, " msi_valid (R11)"}, 64'(msi_valid), 64'(m_msi));
  endtask

  always @(negedge clk) if (cmp_on && !done) begin
    chk("R5 pend_o per clock", 64'(pend_o), 64'(vec_p()));
    chk("R8 en_o per clock", 64'(en_o), 64'(vec_e()));
    chk("R2 ie_o per clock", 64'(ie_o), 64'(m_ie));
  end

  initial begin
    #4_000_000;
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_md[i] = 0; m_p[i] = 0; m_e[i] = 0; m_t[i] = 0; end
    m_ie = 0; m_gen = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    chk("R12 pend_o reset", 64'(pend_o), 64'd0);
    chk("R12 en_o reset", 64'(en_o), 64'd0);
    chk("R12 rsp_valid idle", 64'(rsp_valid), 64'd0);
    cmp_on = 1;
    acc("R12 R2 domcfg read", 0, 'h0000, 0);
    acc("R12 genmsi read", 0, 'h3000, 0);
    acc("R12 cfg src5 read", 0, 'h0014, 0);
    // R2
    acc("R2 domcfg write", 1, 'h0000, 32'hFFFF_FFFF);
    acc("R2 domcfg readback", 0, 'h0000, 0);
    // R3
    acc("R3 delegate write", 1, 'h0004, 32'h0000_0406);
    acc("R3 src1 read", 0, 'h0004, 0);
    acc("R3 mask write", 1, 'h0004, 32'h0000_00FE);
    acc("R3 src1 read mode6", 0, 'h0004, 0);
    acc("R3 src2 lvl low", 1, 'h0008, 7);
    acc("R3 src3 rise", 1, 'h000C, 4);
    acc("R3 src4 fall", 1, 'h0010, 5);
    acc("R3 src6 lvl high", 1, 'h0018, 6);
    acc("R3 src33 detached", 1, 'h0004 + 4*32, 1);
    acc("R3 src39 rise", 1, 'h0004 + 4*38, 4);
    acc("R3 src39 read", 0, 'h0004 + 4*38, 0);
    src[6] = 1;
    // R5 R6: mixed modes in one bitmap write
    acc("R6 setp word0", 1, 'h1C00, 32'hFFFF_FFFF);
    acc("R5 setp word0 read", 0, 'h1C00, 0);
    acc("R5 setp word1", 1, 'h1C04, 32'hFFFF_FFFF);
    acc("R5 setp word1 read", 0, 'h1C04, 0);
    // R7
    acc("R7 rect read w0", 0, 'h1D00, 0);
    acc("R7 rect read w1", 0, 'h1D04, 0);
    acc("R7 clrp bits 2,3", 1, 'h1D00, 32'h0000_000C);
    acc("R7 setp after clear", 0, 'h1C00, 0);
    // R6: inactive ignores clear
    acc("R6 src3 pend", 1, 'h1CDC, 3);
    acc("R6 src3 to inactive", 1, 'h000C, 0);
    acc("R6 clr inactive src3", 1, 'h1DDC, 3);
    acc("R6 src3 still pending", 0, 'h1C00, 0);
    // R9
    acc("R9 setpnum src1 input low", 1, 'h1CDC, 1);
    src[1] = 1;
    acc("R9 setpnum src1 input high", 1, 'h1CDC, 1);
    acc("R9 setpnum zero", 1, 'h1CDC, 0);
    acc("R9 setpnum out of range", 1, 'h1CDC, 40);
    acc("R9 setpnum reads 0", 0, 'h1CDC, 0);
    acc("R9 clrpnum src4", 1, 'h1DDC, 4);
    acc("R9 le alias src4", 1, 'h2000, 4);
    acc("R9 le alias reads 0", 0, 'h2000, 0);
    acc("R9 clrpnum src33", 1, 'h1DDC, 33);
    // R10
    acc("R10 be alias src33", 1, 'h2004, 32'h2100_0000);
    acc("R10 be reads 0", 0, 'h2004, 0);
    acc("R10 setp word1 read", 0, 'h1C04, 0);
    // same-cycle: input change with set request on level-high src6
    acc("R6 clr src6", 1, 'h1DDC, 6);
    src[6] = 0;
    acc("R6 set src6 input falls same cycle", 1, 'h1CDC, 6);
    src[6] = 1;
    acc("R6 set src6 input rises same cycle", 1, 'h1CDC, 6);
    // R8
    acc("R8 sete w0", 1, 'h1E00, 32'h0000_00F1);
    acc("R8 sete w1", 1, 'h1E04, 32'h0000_0080);
    acc("R8 sete read", 0, 'h1E00, 0);
    acc("R8 clre reads 0", 0, 'h1F00, 0);
    acc("R8 clre bit5", 1, 'h1F00, 32'h0000_0020);
    acc("R9 clrenum src4", 1, 'h1FDC, 4);
    acc("R9 setenum src39", 1, 'h1EDC, 39);
    acc("R9 setenum zero", 1, 'h1EDC, 0);
    acc("R8 sete w1 read", 0, 'h1E04, 0);
    // R11
    acc("R11 genmsi write", 1, 'h3000, 32'hFFFF_FFFF);
    chk("R11 msi_hart", 64'(msi_hart), 64'h3FFF);
    chk("R11 msi_eiid", 64'(msi_eiid), 64'h7FF);
    acc("R11 genmsi read", 0, 'h3000, 0);
    acc("R11 genmsi write2", 1, 'h3000, 32'h0004_5123);
    chk("R11 msi_hart 2", 64'(msi_hart), 64'h1);
    chk("R11 msi_eiid 2", 64'(msi_eiid), 64'h123);
    // R4
    acc("R4 tgt src1 write", 1, 'h3004, 32'hFFFF_FFFF);
    acc("R4 tgt src39 write", 1, 'h3004 + 4*38, 32'h1234_5E78);
    acc("R4 tgt src1 read", 0, 'h3004, 0);
    acc("R4 tgt src39 read", 0, 'h3004 + 4*38, 0);
    // R1
    acc("R1 misaligned read", 0, 'h0002, 0);
    acc("R1 size 2 write", 1, 'h0000, 0, 2);
    acc("R1 size 2 setp write", 1, 'h1C00, 32'hFFFF_FFFF, 2);
    acc("R1 cfg past end", 0, 'h00A0, 0);
    acc("R1 setp word2", 1, 'h1C08, 32'hFFFF_FFFF);
    acc("R1 tgt past end", 0, 'h30A0, 0);
    acc("R1 unmapped", 0, 'h1234, 0);
    acc("R2 ie still set", 0, 'h0000, 0);
    acc("R2 ie clear", 1, 'h0000, 0);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule